// File: doc/BRIEF.md
# Serial Echo Bus Controller

This block is a small bus master that stands in for a processor on the host side of a UART. It watches the UART's received-data flag. When a character has arrived, it runs a single read cycle on the shared bidirectional data bus and keeps the byte. It then waits for the UART's transmit-ready flag and runs a single write cycle that puts the same byte back on the bus. The result is that every character typed on a terminal comes back to it unchanged.

The controller is a four-state Moore machine. The states are:

- `ST_IDLE`: polls the received-data flag.
- `ST_READ`: a one-cycle read strobe, during which the byte is captured.
- `ST_WAIT`: polls the transmit-ready flag.
- `ST_WRITE`: a one-cycle write strobe, with the kept byte driven onto the bus.

The transitions are:

- IDLE→READ when `rx_avail` is high.
- READ→WAIT unconditionally.
- WAIT→WRITE when `tx_ready` is high.
- WRITE→IDLE unconditionally.
- Synchronous reset returns the machine to IDLE from any state.

The controller holds only one byte. A character that arrives while it is busy is not read until the machine is back in IDLE.

Top module: `echo_master`

## Requirements
- R1: A synchronous active-high reset places the machine in IDLE. The cycle after reset shows `sel` = 0, `rd_wr_n` = 1 and the bus released, even if reset arrives in the middle of an exchange.
- R2: In IDLE with `rx_avail` low, no bus cycle is started (`sel` stays 0).
- R3: `rx_avail` high in IDLE starts a read cycle on the next cycle. A read cycle is `sel` = 1 with `rd_wr_n` = 1, lasting exactly one cycle.
- R4: The bus value present during the read cycle is the value later driven during the write cycle, unchanged.
- R5: After a read, the machine waits while `tx_ready` is low. During this wait `sel` stays 0, `rd_wr_n` stays 1 and the bus is released.
- R6: `tx_ready` high while waiting starts a write cycle on the next cycle. A write cycle is `sel` = 1 with `rd_wr_n` = 0 and the kept byte on `data_bus`, lasting exactly one cycle.
- R7: The cycle after a write cycle is idle: `sel` = 0 and the bus is released.
- R8: `rx_avail` raised while a byte is being held has no effect until the write cycle for that byte completes. The next read cycle then follows one idle cycle after the write.
- R9: `tx_ready` alone in IDLE starts no cycle. When `rx_avail` and `tx_ready` are both high in IDLE, the read cycle comes first.
- R10: The block drives `data_bus` only during a write cycle, and `rd_wr_n` is 1 in every cycle that is not a write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_avail | input | 1 | UART flag: a received byte is ready to be read |
| tx_ready | input | 1 | UART flag: the transmit buffer is empty |
| sel | output | 1 | Chip select for the UART bus cycle |
| rd_wr_n | output | 1 | 1 = read cycle, 0 = write cycle |
| data_bus | inout | DW (8) | Shared bidirectional data bus |

## Verification
The received-data flag and the transmit-ready flag can both be high in the same cycle. This happens in IDLE, and it also happens when a new character arrives while the held byte is still waiting to be written.

The bench raises both flags on the same clock in IDLE and checks that a read cycle, not a write, follows. It also raises `rx_avail` during the wait and checks that no read strobe appears until one idle cycle after the write. Finally, the second byte is traced through to its own echo.

// File: rtl/echo_pkg.sv
package echo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } echo_state_t;

    typedef struct packed {
        logic sel;
        logic rd_wr_n;
        logic cap_en;
        logic drv_en;
    } echo_ctl_t;

    localparam echo_ctl_t CTL_QUIET = '{sel: 1'b0, rd_wr_n: 1'b1, cap_en: 1'b0, drv_en: 1'b0};

endpackage

// File: rtl/echo_fsm.sv
module echo_fsm
    import echo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_avail,
    input  logic        tx_ready,
    output echo_state_t state_q,
    output echo_ctl_t   ctl
);

    echo_state_t state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rx_avail) state_d = ST_READ;
            ST_READ:  state_d = ST_WAIT;
            ST_WAIT:  if (tx_ready) state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        ctl = CTL_QUIET;
        unique case (state_q)
            ST_IDLE:  ctl = CTL_QUIET;
            ST_READ:  begin
                ctl.sel     = 1'b1;
                ctl.rd_wr_n = 1'b1;
                ctl.cap_en  = 1'b1;
            end
            ST_WAIT:  ctl = CTL_QUIET;
            ST_WRITE: begin
                ctl.sel     = 1'b1;
                ctl.rd_wr_n = 1'b0;
                ctl.drv_en  = 1'b1;
            end
            default:  ctl = CTL_QUIET;
        endcase
    end

endmodule

// File: rtl/echo_hold.sv
module echo_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_en,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] hold_q
);

    always_ff @(posedge clk) begin
        if (rst)         hold_q <= '0;
        else if (cap_en) hold_q <= bus_in;
    end

endmodule

// File: rtl/echo_master.sv
module echo_master #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_avail,
    input  logic          tx_ready,
    output logic          sel,
    output logic          rd_wr_n,
    inout  wire  [DW-1:0] data_bus
);
    import echo_pkg::*;

    echo_state_t   state_q;
    echo_ctl_t     ctl;
    logic [DW-1:0] hold_q;
    logic          drv_en;

    echo_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .rx_avail (rx_avail),
        .tx_ready (tx_ready),
        .state_q  (state_q),
        .ctl      (ctl)
    );

    echo_hold #(.DW(DW)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .cap_en (ctl.cap_en),
        .bus_in (data_bus),
        .hold_q (hold_q)
    );

    assign sel      = ctl.sel;
    assign rd_wr_n  = ctl.rd_wr_n;
    assign drv_en   = ctl.drv_en;
    assign data_bus = drv_en ? hold_q : {DW{1'bz}};

endmodule

// File: rtl/echo_master_chk.sv
module echo_master_chk #(
    parameter int DW = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  rx_avail,
    input logic                  tx_ready,
    input logic                  sel,
    input logic                  rd_wr_n,
    input logic                  drv_en,
    input logic [DW-1:0]         data_bus,
    input echo_pkg::echo_state_t state_q
);
    import echo_pkg::*;

    logic [DW-1:0] seen_q;
    logic          live_q;

    always_ff @(posedge clk) begin
        if (rst) live_q <= 1'b1;
        if (sel && rd_wr_n) seen_q <= data_bus;
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        live_q && $past(rst) |-> !sel && rd_wr_n && !drv_en);

    assert_no_cycle_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !rx_avail) |=> !sel);

    assert_read_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && rx_avail) |=> (sel && rd_wr_n));

    assert_read_single_R3: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_wr_n) |=> !sel);

    assert_echo_same_R4: assert property (@(posedge clk) disable iff (rst)
        (sel && !rd_wr_n) |-> data_bus == seen_q);

    assert_wait_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !tx_ready) |=> (!sel && !drv_en));

    assert_write_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && tx_ready) |=> (sel && !rd_wr_n));

    assert_write_single_R7: assert property (@(posedge clk) disable iff (rst)
        (sel && !rd_wr_n) |=> !sel);

    assert_drive_only_write_R10: assert property (@(posedge clk) disable iff (rst)
        drv_en |-> (sel && !rd_wr_n));

endmodule

bind echo_master echo_master_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_avail (rx_avail),
    .tx_ready (tx_ready),
    .sel      (sel),
    .rd_wr_n  (rd_wr_n),
    .drv_en   (drv_en),
    .data_bus (data_bus),
    .state_q  (state_q)
);

// File: tb/test_echo_master.sv
`timescale 1ns/1ps
module test_echo_master;

    localparam int DW = 8;
    localparam int NV = 6;
    // {byte, extra wait cycles before tx_ready}
    localparam logic [15:0] VEC [NV] = '{
        16'hA5_00, 16'h3C_02, 16'h00_01, 16'hFF_04, 16'h5A_00, 16'h81_03
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_avail = 1'b0;
    logic tx_ready = 1'b0;
    logic sel, rd_wr_n;
    logic [DW-1:0] rx_byte = '0;
    wire  [DW-1:0] data_bus;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    // UART model drives the bus only during read strobes
    assign data_bus = (sel && rd_wr_n) ? rx_byte : {DW{1'bz}};

    echo_master #(.DW(DW)) i_echo_master (
        .clk      (clk),
        .rst      (rst),
        .rx_avail (rx_avail),
        .tx_ready (tx_ready),
        .sel      (sel),
        .rd_wr_n  (rd_wr_n),
        .data_bus (data_bus)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // called at a negedge with the machine in WAIT holding b
    task automatic do_write(input logic [DW-1:0] b, input int dly);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            chk("R5 quiet while waiting", {sel, rd_wr_n}, 2'b01);
        end
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R6 write strobe", {sel, rd_wr_n}, 2'b10);
        chk("R4 echoed byte", data_bus, b);
        tx_ready = 1'b0;
        @(negedge clk);
        chk("R7 idle after write", {sel, rd_wr_n}, 2'b01);
    endtask

    task automatic echo_one(input logic [DW-1:0] b, input int dly);
        @(negedge clk);
        rx_byte  = b;
        rx_avail = 1'b1;
        @(negedge clk);
        chk("R3 read strobe", {sel, rd_wr_n}, 2'b11);
        rx_avail = 1'b0;
        @(negedge clk);
        chk("R5 wait entered", {sel, rd_wr_n}, 2'b01);
        do_write(b, dly);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset outputs", {sel, rd_wr_n}, 2'b01);

        // R2 idle, R9 tx_ready alone ignored
        tx_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R2 R9 no cycle in idle", sel, 1'b0);
        end
        tx_ready = 1'b0;

        // table-driven echoes
        for (int v = 0; v < NV; v++)
            echo_one(VEC[v][15:8], int'(VEC[v][7:0]));

        // R9: both flags high in idle, read comes first
        @(negedge clk);
        rx_byte  = 8'hC3;
        rx_avail = 1'b1;
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R9 read before write", {sel, rd_wr_n}, 2'b11);
        rx_avail = 1'b0;
        @(negedge clk);
        chk("R10 rd_wr_n high in wait", {sel, rd_wr_n}, 2'b01);
        @(negedge clk);
        chk("R6 write with ready already high", {sel, rd_wr_n}, 2'b10);
        chk("R4 byte after simultaneous flags", data_bus, 8'hC3);
        tx_ready = 1'b0;
        @(negedge clk);
        chk("R7 idle after write", sel, 1'b0);

        // R8: second byte arrives while holding the first
        @(negedge clk);
        rx_byte  = 8'h6E;
        rx_avail = 1'b1;
        @(negedge clk);
        chk("R3 read strobe", {sel, rd_wr_n}, 2'b11);
        rx_avail = 1'b0;
        @(negedge clk);
        rx_byte  = 8'h17;
        rx_avail = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 no read while holding", sel, 1'b0);
        end
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R6 first byte written", {sel, rd_wr_n}, 2'b10);
        chk("R8 first byte kept", data_bus, 8'h6E);
        tx_ready = 1'b0;
        @(negedge clk);
        chk("R8 idle gap after write", sel, 1'b0);
        @(negedge clk);
        chk("R8 pending byte read", {sel, rd_wr_n}, 2'b11);
        rx_avail = 1'b0;
        @(negedge clk);
        do_write(8'h17, 1);

        // R1: reset in the middle of an exchange
        @(negedge clk);
        rx_byte  = 8'h99;
        rx_avail = 1'b1;
        @(negedge clk);
        rx_avail = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid exchange", {sel, rd_wr_n}, 2'b01);
        rst = 1'b0;
        tx_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1 no write after reset", sel, 1'b0);
        end
        tx_ready = 1'b0;

        echo_one(8'h42, 0);
        finish_run();
    end

endmodule